// File: doc/BRIEF.md
# Two-Level Lookahead Carry Network

This block is a purely combinational carry network for a 32-bit adder. It receives a propagate bit and a generate bit for each position, plus a carry-in. From these it forms every internal carry and the carry-out in parallel. It also exports a block propagate and a block generate so that a wider adder can cascade several copies. Sum formation and operand preparation are done by the surrounding datapath.

The network has three tiers, all built from one lookahead unit. The first tier has four-bit units that expand each carry inside their group and report a group propagate and a group generate. In the second tier, one unit per 16-bit super-block combines four group pairs and supplies the carry-in of each group. A final two-way unit joins the two super-blocks, producing the carry at bit 16 and the carry-out. No carry passes serially from one bit to the next.

Top module: `cla_carry_net`

## Requirements
- R1: For k = 1..32, carry_o[k] equals c(k), where c(0) = c_i and c(k) = g_i[k-1] | (p_i[k-1] & c(k-1)). This holds for arbitrary propagate and generate patterns, including positions where both bits are set.
- R2: carry_o[32] is the carry-out of the whole 32-bit span.
- R3: blk_p_o is the AND of all 32 propagate bits. blk_g_o equals the carry-out that the network would produce with c_i = 0.
- R4: When every propagate bit is 1 and every generate bit is 0, every carry_o bit equals c_i. When both vectors are all zero, every carry_o bit is 0 for either c_i.
- R5: If g_i[i] is 1, then carry_o[i+1] is 1, whatever the other inputs are.
- R6: At each four-bit group boundary (carry_o[4], [8], ... [32]), the carry that the second-level or top-level lookahead supplies agrees with the carry that the group's own four-bit expansion forms.
- R7: The carry into the upper super-block (carry_o[16]) from the top stage agrees with the carry that the lower super-block forms internally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| p_i | input | 32 | Per-bit carry propagate |
| g_i | input | 32 | Per-bit carry generate |
| c_i | input | 1 | Carry into bit 0 |
| carry_o | output | 32 | Carries into bits 1..31 and carry-out at index 32 (range [32:1]) |
| blk_p_o | output | 1 | Block propagate over all 32 bits |
| blk_g_o | output | 1 | Block generate over all 32 bits |

## Verification
Every output is a function of the present inputs only, so each result is due in the same cycle as its stimulus, with no register delay. The bench changes the inputs on the rising edge of its pacing clock and reads all outputs on the following falling edge, after the combinational network has settled. Each carry bit, the carry-out and the block propagate and generate pair are compared against a bench ripple model.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_W  = 4;
  localparam int unsigned GRPS   = 4;
  localparam int unsigned SBLKS  = 2;
  localparam int unsigned SB_W   = GRP_W * GRPS;
  localparam int unsigned NET_W  = SB_W * SBLKS;
endpackage

// File: rtl/cla_lookahead.sv
// One lookahead unit: all carries of a WAY-wide span formed in parallel.
module cla_lookahead #(
  parameter int unsigned WAY = 4
) (
  input  logic [WAY-1:0] p_i,
  input  logic [WAY-1:0] g_i,
  input  logic           c_i,
  output logic [WAY:1]   c_o,
  output logic           grp_p_o,
  output logic           grp_g_o
);

  // Sum-of-products carry out of the first k positions.
  function automatic logic span_carry(input logic [WAY-1:0] p,
                                      input logic [WAY-1:0] g,
                                      input logic           cin,
                                      input int unsigned    k);
    logic acc;
    logic term;
    term = cin;
    for (int unsigned j = 0; j < k; j++) term = term & p[j];
    acc = term;
    for (int unsigned j = 0; j < k; j++) begin
      term = g[j];
      for (int unsigned m = j + 1; m < k; m++) term = term & p[m];
      acc = acc | term;
    end
    return acc;
  endfunction

  for (genvar k = 1; k <= WAY; k++) begin : g_carry
    assign c_o[k] = span_carry(p_i, g_i, c_i, k);
  end

  assign grp_p_o = &p_i;
  assign grp_g_o = span_carry(p_i, g_i, 1'b0, WAY);

  always_comb begin
    AST_PASS_THROUGH: assert (!((&p_i) && !(|g_i)) || (c_o[WAY] == c_i)) // R4
      else $error("all-propagate span does not pass carry-in");
    AST_TOP_GENERATE: assert (!g_i[WAY-1] || c_o[WAY]) // R5
      else $error("top generate bit did not force carry");
  end

endmodule

// File: rtl/cla_superblock.sv
// Four-bit groups plus one second-level unit over the group P/G pairs.
module cla_superblock
  import cla_pkg::*;
#(
  parameter int unsigned GW = GRP_W,
  parameter int unsigned NG = GRPS,
  localparam int unsigned W = GW * NG
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         c_i,
  output logic [W:1]   carry_o,
  output logic         sb_p_o,
  output logic         sb_g_o
);

  logic [NG-1:0] grp_p, grp_g;
  logic [NG:1]   l2_c;
  logic [NG-1:0] grp_cin;
  logic [GW:1]   l1_c [NG];

  assign grp_cin[0] = c_i;
  for (genvar j = 1; j < NG; j++) begin : g_cin
    assign grp_cin[j] = l2_c[j];
  end

  for (genvar j = 0; j < NG; j++) begin : g_grp
    cla_lookahead #(.WAY(GW)) i_grp (
      .p_i     (p_i[j*GW +: GW]),
      .g_i     (g_i[j*GW +: GW]),
      .c_i     (grp_cin[j]),
      .c_o     (l1_c[j]),
      .grp_p_o (grp_p[j]),
      .grp_g_o (grp_g[j])
    );
    for (genvar k = 1; k < GW; k++) begin : g_inner
      assign carry_o[j*GW + k] = l1_c[j][k];
    end
    assign carry_o[(j+1)*GW] = l2_c[j+1];
  end

  cla_lookahead #(.WAY(NG)) i_lvl2 (
    .p_i     (grp_p),
    .g_i     (grp_g),
    .c_i     (c_i),
    .c_o     (l2_c),
    .grp_p_o (sb_p_o),
    .grp_g_o (sb_g_o)
  );

  always_comb begin
    for (int j = 0; j < NG; j++) begin
      AST_GRP_BOUNDARY: assert (l1_c[j][GW] == l2_c[j+1]) // R6
        else $error("group %0d boundary carry mismatch", j);
    end
  end

endmodule

// File: rtl/cla_carry_net.sv
// 32-bit carry network: super-blocks joined by a top lookahead stage.
module cla_carry_net
  import cla_pkg::*;
(
  input  logic [NET_W-1:0] p_i,
  input  logic [NET_W-1:0] g_i,
  input  logic             c_i,
  output logic [NET_W:1]   carry_o,
  output logic             blk_p_o,
  output logic             blk_g_o
);

  logic [SBLKS-1:0] sb_p, sb_g, sb_cin;
  logic [SBLKS:1]   top_c;
  logic [SB_W:1]    sb_c [SBLKS];

  assign sb_cin[0] = c_i;
  for (genvar s = 1; s < SBLKS; s++) begin : g_cin
    assign sb_cin[s] = top_c[s];
  end

  for (genvar s = 0; s < SBLKS; s++) begin : g_sb
    cla_superblock #(.GW(GRP_W), .NG(GRPS)) i_sb (
      .p_i     (p_i[s*SB_W +: SB_W]),
      .g_i     (g_i[s*SB_W +: SB_W]),
      .c_i     (sb_cin[s]),
      .carry_o (sb_c[s]),
      .sb_p_o  (sb_p[s]),
      .sb_g_o  (sb_g[s])
    );
    for (genvar k = 1; k < SB_W; k++) begin : g_bits
      assign carry_o[s*SB_W + k] = sb_c[s][k];
    end
    assign carry_o[(s+1)*SB_W] = top_c[s+1];
  end

  cla_lookahead #(.WAY(SBLKS)) i_top (
    .p_i     (sb_p),
    .g_i     (sb_g),
    .c_i     (c_i),
    .c_o     (top_c),
    .grp_p_o (blk_p_o),
    .grp_g_o (blk_g_o)
  );

  always_comb begin
    for (int s = 0; s < SBLKS; s++) begin
      AST_SB_HANDOFF: assert (sb_c[s][SB_W] == top_c[s+1]) // R7
        else $error("super-block %0d carry disagrees with top stage", s);
    end
    AST_KILL_ALL: assert ((|p_i) || (|g_i) || (carry_o == '0)) // R4
      else $error("carry set with no propagate or generate");
  end

endmodule

// File: tb/test_cla_carry_net.sv
module test_cla_carry_net;
  localparam int unsigned N = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG_CYC = 100000;

  logic clk = 1'b0;
  logic [N-1:0] p, g;
  logic cin;
  logic [N:1] carry;
  logic bp, bg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cla_carry_net i_cla_carry_net (
    .p_i(p), .g_i(g), .c_i(cin),
    .carry_o(carry), .blk_p_o(bp), .blk_g_o(bg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N:0] ref_ripple(input logic [N-1:0] pp,
                                            input logic [N-1:0] gg,
                                            input logic c0);
    logic [N:0] c;
    c[0] = c0;
    for (int k = 1; k <= N; k++) c[k] = gg[k-1] | (pp[k-1] & c[k-1]);
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on rising edge, read on falling edge; outputs are combinational.
  task automatic apply(input logic [N-1:0] pp, input logic [N-1:0] gg, input logic c0);
    logic [N:0] r;
    @(posedge clk);
    p = pp; g = gg; cin = c0;
    @(negedge clk);
    r = ref_ripple(pp, gg, c0);
    chk("R1 carries", 64'(carry), 64'(r[N:1]));
    chk("R2 carry-out", 64'(carry[N]), 64'(r[N]));
    chk("R3 block p/g", {62'd0, bp, bg}, {62'd0, &pp, ref_ripple(pp, gg, 1'b0)[N]});
  endtask

  initial begin
    p = '0; g = '0; cin = 1'b0;
    void'($urandom(32'h5eed_c1a0));
    @(negedge clk);
    chk("R4 idle outputs", {31'd0, carry, bp, bg}, 64'd0);

    // R4: all-propagate passes carry-in; all-zero kills it
    for (int c = 0; c < 2; c++) begin
      apply('1, '0, c[0]);
      chk("R4 pass-through", 64'(carry), c[0] ? 64'hFFFF_FFFF : 64'd0);
      apply('0, '0, c[0]);
      chk("R4 kill", 64'(carry), 64'd0);
    end

    // R5: single generate forces next carry
    for (int i = 0; i < N; i += 3) begin
      apply(N'($urandom()), N'(1) << i, 1'b0);
      chk("R5 generate", 64'(carry[i+1]), 64'd1);
    end

    // R6/R7: carry launched at bit 0 travels across every boundary
    apply({{(N-1){1'b1}}, 1'b0}, N'(1), 1'b0);
    chk("R6 group boundaries", 64'({carry[32], carry[28], carry[24], carry[20],
                                    carry[16], carry[12], carry[8], carry[4]}), 64'hFF);
    chk("R7 super-block handoff", 64'(carry[16]), 64'd1);
    apply(32'hFFFF_0000, 32'h0000_8000, 1'b0);
    chk("R7 handoff from generate", 64'({carry[17], carry[32]}), 64'h3);

    // R1: exhaustive per group, other bits random
    for (int grp = 0; grp < N/4; grp++) begin
      for (int v = 0; v < 512; v++) begin
        logic [N-1:0] pp, gg;
        pp = N'($urandom());
        gg = N'($urandom()) & N'($urandom());
        pp[grp*4 +: 4] = v[3:0];
        gg[grp*4 +: 4] = v[7:4];
        apply(pp, gg, v[8]);
      end
    end

    // R1: random mix, biased toward long propagate runs
    for (int n = 0; n < 2000; n++) begin
      logic [N-1:0] pp, gg;
      pp = N'($urandom()) | N'($urandom());
      gg = N'($urandom()) & N'($urandom()) & N'($urandom());
      apply(pp, gg, 1'($urandom()));
    end

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG_CYC) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule